// File: doc/BRIEF.md
# Processor Bus Transaction Classifier

This block watches the control, address and data lines of an 8-bit microprocessor bus from a fast system clock. All bus lines pass through a two-stage synchroniser. From the synchronised active-low lines it decides what kind of transaction is in progress: memory read, memory write, I/O read, I/O write, opcode fetch or interrupt acknowledge. It latches the address when the transaction begins and keeps sampling the data byte while the transaction's strobe stays asserted.

When the strobe is released, the block emits a one-clock event. The event carries the transaction kind, the latched address, an address-valid flag and the data byte. The memory-request line, the I/O-request line and the address bus may be absent on a given board. Each one has a static strap input that says whether it is fitted. A debug or trace collector uses the events as a stream of bus transactions.

Top module: `bus_cycle_tap`

## Requirements
- R1: The kind code on `ev_kind` is 1 for memory read, 2 for memory write, 3 for I/O read, 4 for I/O write, 5 for opcode fetch and 6 for interrupt acknowledge; 0 (none) is never emitted. Interrupt acknowledge is machine-cycle-one low with I/O request low, and it takes priority. Opcode fetch is machine-cycle-one low with read low and memory request low.
- R2: With machine-cycle-one high, I/O request low with read low gives an I/O read (3), and I/O request low with write low gives an I/O write (4). An I/O transaction takes precedence over a memory transaction.
- R3: With machine-cycle-one and I/O request high, memory request low with read low gives a memory read (1), and memory request low with write low gives a memory write (2).
- R4: When `mreq_fitted` is 0, the memory-request input is ignored and treated as asserted, so plain reads and writes classify as memory transactions.
- R5: When `iorq_fitted` is 0, the I/O-request input is ignored and treated as deasserted, so no I/O or interrupt-acknowledge kind is produced.
- R6: `ev_addr` is the address present when the transaction began. Later address changes before the strobe is released have no effect.
- R7: When `addr_fitted` is 0, each event has `ev_addr_ok` = 0 and `ev_addr` = 0. Otherwise `ev_addr_ok` = 1.
- R8: For read-type kinds (1, 3, 5), `ev_data` is the byte on the data bus at the last sample before read goes high.
- R9: For write-type kinds (2, 4), `ev_data` is the last byte sampled while write is low. For interrupt acknowledge, it is the last byte sampled while I/O request is low.
- R10: Each transaction produces exactly one event, and `ev_valid` is high for a single clock. Control activity with no qualifying strobe, such as machine-cycle-one alone, produces no event.
- R11: After reset, `ev_valid` is 0 and no event appears until a transaction completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| m1_n | input | 1 | Machine-cycle-one qualifier, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| mreq_n | input | 1 | Memory request, active low (optional) |
| iorq_n | input | 1 | I/O request, active low (optional) |
| addr | input | 16 | Address bus, bit 0 least significant (optional) |
| data | input | 8 | Data bus, bit 0 least significant |
| mreq_fitted | input | 1 | Strap: memory-request line is connected |
| iorq_fitted | input | 1 | Strap: I/O-request line is connected |
| addr_fitted | input | 1 | Strap: address bus is connected |
| ev_valid | output | 1 | One-clock transaction-end event |
| ev_kind | output | 3 | Transaction kind code |
| ev_addr | output | 16 | Address latched at transaction start |
| ev_addr_ok | output | 1 | Address is valid |
| ev_data | output | 8 | Data byte of the transaction |

## Verification
The embedded assertions check on every cycle that:
- an event lasts one clock and follows an open transaction;
- it never carries the none code;
- the latched address does not move while a transaction is open;
- an invalid address reads as zero;
- the synchroniser output equals its input from two clocks earlier.

Only the scoreboard scenarios can show that the kind decode, the strap defaults, the address latch and the final data byte match the expected transaction. They drive complete bus transactions, change the address and data mid-transaction, and include strobe-less activity that must produce nothing.

// File: rtl/bct_pkg.sv
package bct_pkg;

  typedef enum logic [2:0] {
    CYC_NONE   = 3'd0,
    CYC_MEMRD  = 3'd1,
    CYC_MEMWR  = 3'd2,
    CYC_IORD   = 3'd3,
    CYC_IOWR   = 3'd4,
    CYC_FETCH  = 3'd5,
    CYC_INTACK = 3'd6
  } cyc_kind_e;

  // Priority decode of the effective active-low control lines.
  function automatic cyc_kind_e cyc_classify(input logic m1_n, input logic rd_n,
                                             input logic wr_n, input logic mreq_n,
                                             input logic iorq_n);
    cyc_kind_e k;
    k = CYC_NONE;
    if (!m1_n && !iorq_n)                k = CYC_INTACK;
    else if (!m1_n && !rd_n && !mreq_n)  k = CYC_FETCH;
    else if (m1_n && !iorq_n && !rd_n)   k = CYC_IORD;
    else if (m1_n && !iorq_n && !wr_n)   k = CYC_IOWR;
    else if (m1_n && !mreq_n && !rd_n)   k = CYC_MEMRD;
    else if (m1_n && !mreq_n && !wr_n)   k = CYC_MEMWR;
    return k;
  endfunction

  // Level of the strobe that keeps a transaction of the given kind open (active low).
  function automatic logic cyc_strobe_n(input cyc_kind_e k, input logic rd_n,
                                        input logic wr_n, input logic iorq_n);
    logic s;
    case (k)
      CYC_MEMRD, CYC_IORD, CYC_FETCH: s = rd_n;
      CYC_MEMWR, CYC_IOWR:            s = wr_n;
      CYC_INTACK:                     s = iorq_n;
      default:                        s = 1'b1;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/bct_sync.sv
module bct_sync #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;
  logic [1:0]   warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      dout   <= RST_VAL;
      warm   <= 2'd0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
      if (warm != 2'd2) warm <= warm + 2'd1;
    end
  end

  // Output follows the raw input with a two-clock delay (supports R6, R8, R9)
  p_two_stage_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/bct_decode.sv
module bct_decode
  import bct_pkg::*;
(
  input  logic      m1_n,
  input  logic      rd_n,
  input  logic      wr_n,
  input  logic      mreq_n,
  input  logic      iorq_n,
  input  logic      mreq_fitted,
  input  logic      iorq_fitted,
  output logic      eff_iorq_n,
  output cyc_kind_e kind_now
);
  logic eff_mreq_n;

  // R4: absent memory request reads as asserted; R5: absent I/O request reads as idle
  assign eff_mreq_n = mreq_fitted ? mreq_n : 1'b0;
  assign eff_iorq_n = iorq_fitted ? iorq_n : 1'b1;
  assign kind_now   = cyc_classify(m1_n, rd_n, wr_n, eff_mreq_n, eff_iorq_n);

  always_comb begin
    p_absent_io_quiet_r5: assert (iorq_fitted || !(kind_now inside {CYC_IORD, CYC_IOWR, CYC_INTACK}));
  end
endmodule

// File: rtl/bct_tracker.sv
module bct_tracker
  import bct_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_kind_e     kind_now,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          iorq_n,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] data_s,
  input  logic          addr_fitted,
  output logic          ev_valid,
  output cyc_kind_e     ev_kind,
  output logic [AW-1:0] ev_addr,
  output logic          ev_addr_ok,
  output logic [DW-1:0] ev_data
);
  logic          active;
  cyc_kind_e     kind_q;
  logic [AW-1:0] addr_q;
  logic          ok_q;
  logic [DW-1:0] data_q;
  logic          strobe_held;
  logic          cyc_start;
  logic          cyc_end;

  assign strobe_held = !cyc_strobe_n(kind_q, rd_n, wr_n, iorq_n);
  assign cyc_start   = !active && (kind_now != CYC_NONE);
  assign cyc_end     = active && !strobe_held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      kind_q     <= CYC_NONE;
      addr_q     <= '0;
      ok_q       <= 1'b0;
      data_q     <= '0;
      ev_valid   <= 1'b0;
      ev_kind    <= CYC_NONE;
      ev_addr    <= '0;
      ev_addr_ok <= 1'b0;
      ev_data    <= '0;
    end else begin
      ev_valid <= 1'b0;
      if (cyc_start) begin
        active <= 1'b1;
        kind_q <= kind_now;
        addr_q <= addr_fitted ? addr_s : '0;
        ok_q   <= addr_fitted;
        data_q <= data_s;
      end else if (cyc_end) begin
        active     <= 1'b0;
        ev_valid   <= 1'b1;
        ev_kind    <= kind_q;
        ev_addr    <= addr_q;
        ev_addr_ok <= ok_q;
        ev_data    <= data_q;
      end else if (active) begin
        data_q <= data_s;
      end
    end
  end

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> !ev_valid);
  p_event_after_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_valid) |-> $past(active));
  p_kind_not_none_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_kind != CYC_NONE));
  p_addr_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(addr_q));
  p_bad_addr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_addr_ok) |-> (ev_addr == '0));
endmodule

// File: rtl/bus_cycle_tap.sv
module bus_cycle_tap
  import bct_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m1_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          mreq_n,
  input  logic          iorq_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          mreq_fitted,
  input  logic          iorq_fitted,
  input  logic          addr_fitted,
  output logic          ev_valid,
  output logic [2:0]    ev_kind,
  output logic [AW-1:0] ev_addr,
  output logic          ev_addr_ok,
  output logic [DW-1:0] ev_data
);
  localparam int NCTL = 5;
  localparam int SW   = NCTL + AW + DW;
  localparam logic [SW-1:0] SYNC_RST = {{NCTL{1'b1}}, {(AW + DW){1'b0}}};

  logic [SW-1:0] raw_bus;
  logic [SW-1:0] sync_bus;
  logic          m1_s, rd_s, wr_s, mreq_s, iorq_s;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] data_s;
  logic          eff_iorq_n;
  cyc_kind_e     kind_now;
  cyc_kind_e     ev_kind_e;

  assign raw_bus = {m1_n, rd_n, wr_n, mreq_n, iorq_n, addr, data};
  assign {m1_s, rd_s, wr_s, mreq_s, iorq_s, addr_s, data_s} = sync_bus;

  bct_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_bus), .dout(sync_bus)
  );

  bct_decode u_decode (
    .m1_n(m1_s), .rd_n(rd_s), .wr_n(wr_s), .mreq_n(mreq_s), .iorq_n(iorq_s),
    .mreq_fitted(mreq_fitted), .iorq_fitted(iorq_fitted),
    .eff_iorq_n(eff_iorq_n), .kind_now(kind_now)
  );

  bct_tracker #(.AW(AW), .DW(DW)) u_tracker (
    .clk(clk), .rst_n(rst_n), .kind_now(kind_now),
    .rd_n(rd_s), .wr_n(wr_s), .iorq_n(eff_iorq_n),
    .addr_s(addr_s), .data_s(data_s), .addr_fitted(addr_fitted),
    .ev_valid(ev_valid), .ev_kind(ev_kind_e), .ev_addr(ev_addr),
    .ev_addr_ok(ev_addr_ok), .ev_data(ev_data)
  );

  assign ev_kind = ev_kind_e;

  p_reset_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_valid) |-> $past(rst_n));
endmodule

// File: tb/bus_cycle_tap_bench.sv
module bus_cycle_tap_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mreq_n = 1'b1, iorq_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic mreq_fitted = 1'b1, iorq_fitted = 1'b1, addr_fitted = 1'b1;
  logic        ev_valid;
  logic [2:0]  ev_kind;
  logic [15:0] ev_addr;
  logic        ev_addr_ok;
  logic [7:0]  ev_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [27:0] expq[$];   // {kind, ok, addr, data}
  string       tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_tap u_bus_cycle_tap (
    .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .addr(addr), .data(data),
    .mreq_fitted(mreq_fitted), .iorq_fitted(iorq_fitted), .addr_fitted(addr_fitted),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_addr(ev_addr),
    .ev_addr_ok(ev_addr_ok), .ev_data(ev_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected kind, stated from the requirements with the straps applied.
  function automatic logic [2:0] model_kind(input logic m1, input logic rd, input logic wr,
                                            input logic mq, input logic io);
    logic mreq_on, io_on;
    mreq_on = !mreq_fitted || !mq;
    io_on   = iorq_fitted && !io;
    if (!m1) return io_on ? 3'd6 : ((!rd && mreq_on) ? 3'd5 : 3'd0);
    if (io_on) return !rd ? 3'd3 : (!wr ? 3'd4 : 3'd0);
    if (mreq_on) return !rd ? 3'd1 : (!wr ? 3'd2 : 3'd0);
    return 3'd0;
  endfunction

  // Drive one transaction: address/data change mid-way, then strobe release.
  task automatic bus_txn(input string tag, input logic m1, input logic rd, input logic wr,
                         input logic mq, input logic io, input logic [15:0] a0,
                         input logic [7:0] d_final);
    logic [2:0] k;
    k = model_kind(m1, rd, wr, mq, io);
    @(negedge clk);
    addr = a0; data = ~d_final;
    m1_n = m1; rd_n = rd; wr_n = wr; mreq_n = mq; iorq_n = io;
    repeat (4) @(negedge clk);
    addr = ~a0; data = d_final;
    repeat (3) @(negedge clk);
    if (k != 3'd0) begin
      expq.push_back({k, addr_fitted, addr_fitted ? a0 : 16'h0, d_final});
      tagq.push_back(tag);
    end
    m1_n = 1; rd_n = 1; wr_n = 1; mreq_n = 1; iorq_n = 1;
    repeat (6) @(negedge clk);
  endtask

  // Monitor: pop and compare on every event; flag stray or stretched pulses.
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n && ev_valid) begin
      check("R10 single-clock event", {31'b0, prev_valid}, 32'd0);
      if (expq.size() == 0) begin
        check("R10 unexpected event", 32'd1, 32'd0);
      end else begin
        logic [27:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check({t, " kind"}, {29'b0, ev_kind}, {29'b0, e[27:25]});
        check({t, " addr_ok"}, {31'b0, ev_addr_ok}, {31'b0, e[24]});
        check({t, " addr"}, {16'b0, ev_addr}, {16'b0, e[23:8]});
        check({t, " data"}, {24'b0, ev_data}, {24'b0, e[7:0]});
      end
    end
    prev_valid <= ev_valid;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 ev_valid in reset", {31'b0, ev_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 ev_valid after reset", {31'b0, ev_valid}, 32'd0);

    bus_txn("R1 fetch",        0, 0, 1, 0, 1, 16'h1234, 8'h3E);
    bus_txn("R1 intack",       0, 1, 1, 1, 0, 16'h0038, 8'hFF);
    bus_txn("R1 intack prio",  0, 0, 1, 0, 0, 16'h0066, 8'hC7);
    bus_txn("R3 mem read R8",  1, 0, 1, 0, 1, 16'hA55A, 8'h81);
    bus_txn("R3 mem write R9", 1, 1, 0, 0, 1, 16'hFFFF, 8'h00);
    bus_txn("R2 io read",      1, 0, 1, 1, 0, 16'h00FE, 8'h5A);
    bus_txn("R2 io write",     1, 1, 0, 1, 0, 16'h7F10, 8'hA5);
    bus_txn("R2 io over mem",  1, 0, 1, 0, 0, 16'h0101, 8'h42);
    bus_txn("R10 m1 alone",    0, 1, 1, 1, 1, 16'h2222, 8'h11);

    mreq_fitted = 1'b0;
    bus_txn("R4 read no mreq",  1, 0, 1, 1, 1, 16'h4000, 8'h99);
    bus_txn("R4 write no mreq", 1, 1, 0, 1, 1, 16'h4001, 8'h77);
    bus_txn("R4 fetch no mreq", 0, 0, 1, 1, 1, 16'h0000, 8'hED);
    mreq_fitted = 1'b1;

    iorq_fitted = 1'b0;
    bus_txn("R5 io line ignored", 1, 0, 1, 0, 0, 16'h8080, 8'h24);
    bus_txn("R5 no intack",       0, 1, 1, 1, 0, 16'h0038, 8'h00);
    iorq_fitted = 1'b1;

    addr_fitted = 1'b0;
    bus_txn("R7 no address rd", 1, 0, 1, 0, 1, 16'hBEEF, 8'h6C);
    bus_txn("R7 no address wr", 1, 1, 0, 0, 1, 16'hCAFE, 8'h13);
    addr_fitted = 1'b1;
    bus_txn("R6 addr latch",    1, 1, 0, 0, 1, 16'h0F0F, 8'hF0);

    repeat (10) @(negedge clk);
    check("R10 all events seen", expq.size(), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule